// File: doc/BRIEF.md
# Receive Sampling Delay Sweep Controller

This block searches for a working receive sampling delay on a high-speed card link. When started in one of the two speed modes that need tuning, it walks a 6-bit delay tap upward from 0, programs each tap through a self-clearing update bit, and asks an external trial engine whether a tuning transfer at that tap passes. Every programming step raises the update bit, waits for the hardware to drop it, and then repeats the raise-and-wait once more. The second round works around a timing weakness in the receive path.

While sweeping, the block keeps the longest unbroken run of passing taps. When the sweep ends it programs the tap at the middle of that run, using the same two-round update, and then signals completion. If no tap passes, it flags an error and leaves the delay alone. In a speed mode that does not need tuning, it completes at once and changes nothing.

Top module: `rx_delay_tuner`

## Requirements
- R1: After reset, `tap_o` is 0 and `upd_o`, `trial_req_o`, `done_o` and `err_o` are all low.
- R2: A tuning run sweeps taps 0 to 39 in increasing order, issuing one trial request per tap whose update completed. Taps 40 to 63 are never used.
- R3: Only mode codes 3'b100 and 3'b011 start a sweep. Any other code on `mode_i` at start gives `done_o` with `err_o` low and no update strobe, and `tap_o` keeps its previous value.
- R4: Each tap is programmed by raising `upd_o`, holding it until `upd_clr_i` is seen, dropping it, and doing this a second time. A clean run with a final tap therefore raises `upd_o` 82 times.
- R5: If `upd_clr_i` does not arrive within TMO_CYC cycles of `upd_o` rising, `upd_o` is dropped and the tap counts as failed, with no trial issued for it.
- R6: A failed trial or a timed-out update ends the current passing run. The best run is the longest one, and on a tie the earliest one is kept.
- R7: After the sweep, `tap_o` becomes the best run's last tap minus half its length, rounded down. This tap is programmed with the two-round update before `done_o`.
- R8: If no tap passes, `err_o` rises together with `done_o` and no final update is made, so a run with every update acknowledged raises `upd_o` 80 times.
- R9: `done_o` is high for exactly one cycle per run. `err_o` keeps its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin tuning |
| mode_i | input | 3 | Speed mode code, sampled with start_i |
| upd_clr_i | input | 1 | Hardware indication that the update bit has cleared |
| trial_done_i | input | 1 | Trial engine finished the current trial |
| trial_pass_i | input | 1 | Result of the trial, valid with trial_done_i |
| tap_o | output | 6 | Sampling delay tap being programmed |
| upd_o | output | 1 | Self-clearing tap update bit |
| trial_req_o | output | 1 | One-cycle request to run a trial at tap_o |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No passing tap found; valid from done_o until next start |

## Verification
The pass/fail model is driven with a single mid-range window, windows touching the lowest and highest swept taps, two windows of different lengths, and two windows of equal length. Together these separate "longest wins" from "first or last wins" and show whether a tie is broken toward the earlier run. A missing acknowledge inside a window checks that a timeout splits a run, and its strobe count shows the dropped round. An all-fail pattern, untuned mode codes, and strobe counts show the error path and the two-round update.

// File: rtl/rx_delay_tuner_pkg.sv
package rx_delay_tuner_pkg;
  localparam int TAP_W    = 6;
  localparam int TAP_LAST = 39;
  localparam logic [2:0] MODE_TUNE_A = 3'b100;
  localparam logic [2:0] MODE_TUNE_B = 3'b011;

  typedef enum logic [2:0] {
    S_IDLE, S_UPD, S_TWAIT, S_STEP
  } ctl_state_t;

  typedef enum logic [1:0] {
    H_IDLE, H_WAIT, H_GAP
  } hs_state_t;

  function automatic logic mode_needs_tuning(input logic [2:0] m);
    return (m == MODE_TUNE_A) || (m == MODE_TUNE_B);
  endfunction
endpackage

// File: rtl/tap_update_hs.sv
module tap_update_hs #(
  parameter int TMO_CYC = 16,
  parameter int ROUNDS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic clr_i,
  output logic upd_o,
  output logic ok_o,
  output logic tmo_o
);
  import rx_delay_tuner_pkg::*;
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam int RW = $clog2(ROUNDS + 1);

  hs_state_t       st;
  logic [CW-1:0]   cnt;
  logic [RW-1:0]   rnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= H_IDLE;
      cnt   <= '0;
      rnd   <= '0;
      upd_o <= 1'b0;
      ok_o  <= 1'b0;
      tmo_o <= 1'b0;
    end else begin
      ok_o  <= 1'b0;
      tmo_o <= 1'b0;
      unique case (st)
        H_IDLE: if (go_i) begin
          upd_o <= 1'b1;
          cnt   <= '0;
          rnd   <= RW'(1);
          st    <= H_WAIT;
        end
        H_WAIT: begin
          if (clr_i) begin
            upd_o <= 1'b0;
            if (rnd == RW'(ROUNDS)) begin
              ok_o <= 1'b1;
              st   <= H_IDLE;
            end else begin
              st <= H_GAP;
            end
          end else if (cnt == CW'(TMO_CYC - 1)) begin
            upd_o <= 1'b0;
            tmo_o <= 1'b1;
            st    <= H_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        H_GAP: begin
          upd_o <= 1'b1;
          cnt   <= '0;
          rnd   <= rnd + 1'b1;
          st    <= H_WAIT;
        end
        default: st <= H_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pass_run_tracker.sv
module pass_run_tracker #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             eval_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W-1:0] best_len_o,
  output logic [TAP_W-1:0] best_end_o
);
  logic [TAP_W-1:0] cur_len;
  logic [TAP_W-1:0] cur_next;

  assign cur_next = cur_len + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cur_len    <= '0;
      best_len_o <= '0;
      best_end_o <= '0;
    end else if (eval_i) begin
      if (pass_i) begin
        cur_len <= cur_next;
        if (cur_next > best_len_o) begin
          best_len_o <= cur_next;
          best_end_o <= tap_i;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end
endmodule

// File: rtl/rx_delay_tuner.sv
module rx_delay_tuner #(
  parameter int TMO_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [2:0] mode_i,
  input  logic       upd_clr_i,
  input  logic       trial_done_i,
  input  logic       trial_pass_i,
  output logic [5:0] tap_o,
  output logic       upd_o,
  output logic       trial_req_o,
  output logic       done_o,
  output logic       err_o
);
  import rx_delay_tuner_pkg::*;

  ctl_state_t       st;
  logic             final_q;
  logic             hs_go;
  logic             hs_ok;
  logic             hs_tmo;
  logic             ev_valid;
  logic             ev_pass;
  logic             trk_clear;
  logic [TAP_W-1:0] best_len;
  logic [TAP_W-1:0] best_end;

  tap_update_hs #(.TMO_CYC(TMO_CYC), .ROUNDS(2)) hs_i (
    .clk(clk), .rst(rst), .go_i(hs_go), .clr_i(upd_clr_i),
    .upd_o(upd_o), .ok_o(hs_ok), .tmo_o(hs_tmo)
  );

  assign trk_clear = (st == S_IDLE) && start_i && mode_needs_tuning(mode_i);
  assign ev_valid  = ((st == S_UPD) && hs_tmo && !final_q) ||
                     ((st == S_TWAIT) && trial_done_i);
  assign ev_pass   = (st == S_TWAIT) && trial_pass_i;

  pass_run_tracker #(.TAP_W(TAP_W)) trk_i (
    .clk(clk), .rst(rst), .clear_i(trk_clear), .eval_i(ev_valid),
    .pass_i(ev_pass), .tap_i(tap_o),
    .best_len_o(best_len), .best_end_o(best_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      tap_o       <= '0;
      final_q     <= 1'b0;
      hs_go       <= 1'b0;
      trial_req_o <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      hs_go       <= 1'b0;
      trial_req_o <= 1'b0;
      done_o      <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          err_o <= 1'b0;
          if (mode_needs_tuning(mode_i)) begin
            tap_o   <= '0;
            final_q <= 1'b0;
            hs_go   <= 1'b1;
            st      <= S_UPD;
          end else begin
            done_o <= 1'b1;
          end
        end
        S_UPD: begin
          if (hs_ok) begin
            if (final_q) begin
              done_o <= 1'b1;
              st     <= S_IDLE;
            end else begin
              trial_req_o <= 1'b1;
              st          <= S_TWAIT;
            end
          end else if (hs_tmo) begin
            if (final_q) begin
              err_o  <= 1'b1;
              done_o <= 1'b1;
              st     <= S_IDLE;
            end else begin
              st <= S_STEP;
            end
          end
        end
        S_TWAIT: if (trial_done_i) st <= S_STEP;
        S_STEP: begin
          if (tap_o == TAP_W'(TAP_LAST)) begin
            if (best_len == '0) begin
              err_o  <= 1'b1;
              done_o <= 1'b1;
              st     <= S_IDLE;
            end else begin
              tap_o   <= best_end - (best_len >> 1);
              final_q <= 1'b1;
              hs_go   <= 1'b1;
              st      <= S_UPD;
            end
          end else begin
            tap_o <= tap_o + 1'b1;
            hs_go <= 1'b1;
            st    <= S_UPD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_delay_tuner_chk.sv
module rx_delay_tuner_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic [5:0] tap_o,
  input logic       upd_o,
  input logic       trial_req_o,
  input logic       done_o,
  input logic       err_o
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);
  a_r9_err_cleared_by_start: assert property (@(posedge clk) disable iff (rst)
    $fell(err_o) |-> $past(start_i));
  a_r4_no_trial_during_update: assert property (@(posedge clk) disable iff (rst)
    trial_req_o |-> !upd_o);
  a_r2_tap_in_range: assert property (@(posedge clk) disable iff (rst)
    tap_o <= 6'd39);
  a_r4_tap_steady_while_update: assert property (@(posedge clk) disable iff (rst)
    (upd_o && $past(upd_o)) |-> $stable(tap_o));
endmodule

bind rx_delay_tuner rx_delay_tuner_chk chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .tap_o(tap_o), .upd_o(upd_o),
  .trial_req_o(trial_req_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/rx_delay_tuner_tb_top.sv
module rx_delay_tuner_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic       upd_clr_i = 1'b0;
  logic       trial_done_i = 1'b0;
  logic       trial_pass_i = 1'b0;
  logic [5:0] tap_o;
  logic       upd_o, trial_req_o, done_o, err_o;

  int n_chk = 0, n_bad = 0;
  int lo1 = 63, hi1 = 0, lo2 = 63, hi2 = 0;
  int bad_tap = -1;
  int rises = 0, trials = 0, last_trial = -1;
  bit seq_bad = 1'b0, upd_prev = 1'b0, summary_done = 1'b0;

  always #5 clk = ~clk;

  rx_delay_tuner #(.TMO_CYC(16)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .upd_clr_i(upd_clr_i), .trial_done_i(trial_done_i),
    .trial_pass_i(trial_pass_i), .tap_o(tap_o), .upd_o(upd_o),
    .trial_req_o(trial_req_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // update-bit hardware model: clears the bit two cycles after it rises
  initial forever begin
    @(negedge clk);
    if (upd_o && !rst && (int'(tap_o) != bad_tap)) begin
      repeat (2) @(negedge clk);
      upd_clr_i = 1'b1;
      @(negedge clk);
      upd_clr_i = 1'b0;
    end
  end

  // trial engine model
  initial forever begin
    @(negedge clk);
    if (trial_req_o) begin
      if (int'(tap_o) <= last_trial) seq_bad = 1'b1;
      last_trial = int'(tap_o);
      trials++;
      repeat (3) @(negedge clk);
      trial_pass_i = ((int'(tap_o) >= lo1) && (int'(tap_o) <= hi1)) ||
                     ((int'(tap_o) >= lo2) && (int'(tap_o) <= hi2));
      trial_done_i = 1'b1;
      @(negedge clk);
      trial_done_i = 1'b0;
      trial_pass_i = 1'b0;
    end
  end

  // strobe counter
  initial forever begin
    @(negedge clk);
    if (upd_o && !upd_prev) rises++;
    upd_prev = upd_o;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run_case(input string name, input logic [2:0] mode,
                          input int l1, input int h1, input int l2, input int h2,
                          input int bt, input int exp_tap, input bit exp_err,
                          input int exp_rises, input int exp_trials);
    int waited;
    lo1 = l1; hi1 = h1; lo2 = l2; hi2 = h2; bad_tap = bt;
    rises = 0; trials = 0; last_trial = -1; seq_bad = 1'b0;
    @(negedge clk);
    start_i = 1'b1; mode_i = mode;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    if (!done_o) begin
      chk(1'b0, {"R9 done missing ", name}, 0, 1);
      return;
    end
    chk(int'(tap_o) == exp_tap, {"R7 final tap ", name}, tap_o, exp_tap);
    chk(err_o == exp_err, {"R8 error flag ", name}, err_o, exp_err);
    chk(rises == exp_rises, {"R4 update strobes ", name}, rises, exp_rises);
    chk(trials == exp_trials, {"R2 trial count ", name}, trials, exp_trials);
    chk(!seq_bad, {"R2 tap order ", name}, seq_bad, 0);
    @(negedge clk);
    chk(!done_o, {"R9 done one cycle ", name}, done_o, 0);
    repeat (5) @(negedge clk);
    chk(err_o == exp_err, {"R9 error held ", name}, err_o, exp_err);
  endtask

  task automatic t_reset();
    chk(tap_o == 6'd0, "R1 reset tap", tap_o, 0);
    chk(!upd_o && !trial_req_o, "R1 reset strobes", {upd_o, trial_req_o}, 0);
    chk(!done_o && !err_o, "R1 reset flags", {done_o, err_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // R7 single mid window [10,19]: 19 - 10/2 = 14
    run_case("mid", 3'b100, 10, 19, 63, 0, -1, 14, 1'b0, 82, 40);
    // R6 longer second window [20,26] beats [5,8]: 26 - 3 = 23
    run_case("longest", 3'b011, 5, 8, 20, 26, -1, 23, 1'b0, 82, 40);
    // R6 equal runs [3,6] and [20,23]: earliest kept, 6 - 2 = 4
    run_case("tie", 3'b100, 3, 6, 20, 23, -1, 4, 1'b0, 82, 40);
    // R7 edges: window [0,0] -> 0, window [30,39] -> 34
    run_case("low edge", 3'b100, 0, 0, 63, 0, -1, 0, 1'b0, 82, 40);
    run_case("high edge", 3'b011, 30, 39, 63, 0, -1, 34, 1'b0, 82, 40);
    // R3 untuned mode keeps tap 34, no strobes
    run_case("untuned", 3'b010, 0, 39, 63, 0, -1, 34, 1'b0, 0, 0);
    run_case("untuned2", 3'b101, 0, 39, 63, 0, -1, 34, 1'b0, 0, 0);
    // R5 timeout at tap 15 splits [10,19] into [10,14] and [16,19]: 14 - 2 = 12
    run_case("timeout", 3'b100, 10, 19, 63, 0, 15, 12, 1'b0, 81, 39);
    // R8 no passing tap: error, tap left at 39, 80 strobes
    run_case("nopass", 3'b100, 63, 0, 63, 0, -1, 39, 1'b1, 80, 40);
    // R9 next start clears error (untuned start)
    run_case("clear err", 3'b000, 63, 0, 63, 0, -1, 39, 1'b0, 0, 0);
    // R2 full window: 39 - 20 = 19
    run_case("all pass", 3'b011, 0, 39, 63, 0, -1, 19, 1'b0, 82, 40);
    finish_run();
  end
endmodule